// File: doc/BRIEF.md
# Up/Down Timer Counter with Bus-Write Precedence

The block is a 16-bit timer counter. It advances by one on each single-cycle count-enable pulse from an external prescaler. A direction input chooses whether it counts up or down. Wrapping past the top of the range raises a sticky overflow flag, and wrapping past zero raises a sticky underflow flag.

A host bus can load the counter or clear the flags through a two-phase write cycle. The request cycle is phase one. The following cycle is phase two, and the write takes effect at the clock edge that ends phase two.

When a count pulse arrives during phase two of a counter write, the written value is loaded and the pulse is lost. Any wrap that the lost pulse would have caused leaves its flag untouched. A count pulse during phase one is applied normally, and the write then replaces the result.

Top module: `updn_timer`

## Requirements
- R1: While `rst_ni` is low, `cnt_o` is 0 and both flags are 0.
- R2: With no load in effect, a cycle with `cnt_en_i`=1 changes `cnt_o` at the next edge by +1 when `dir_down_i`=0 and by -1 when `dir_down_i`=1. A cycle with `cnt_en_i`=0 leaves `cnt_o` unchanged.
- R3: Counting up from 16'hFFFF gives 16'h0000 and sets `ovf_o` at the same edge.
- R4: Counting down from 16'h0000 gives 16'hFFFF and sets `udf_o` at the same edge.
- R5: A cycle with `bus_req_i`=1 and `bus_sel_i`=0 starts a counter write (phase one). `cnt_o` equals the captured `bus_wdata_i` after the edge that ends the next cycle (phase two).
- R6: A count pulse during phase two of a counter write is discarded, and `cnt_o` takes the written value.
- R7: An up-count from 16'hFFFF during phase two of a counter write does not set `ovf_o`.
- R8: A down-count from 16'h0000 during phase two of a counter write does not set `udf_o`.
- R9: A count pulse during phase one is applied normally, including its flag effect, before the phase-two load.
- R10: The flags hold until cleared. A status write (`bus_sel_i`=1) clears `ovf_o` when data bit 0 is 0 and clears `udf_o` when data bit 1 is 0. A bit written as 1 leaves its flag unchanged.
- R11: When a wrap event and a status-write clear of the same flag meet at the same edge, the flag ends set.
- R12: A `bus_req_i` raised during phase two is ignored, so it starts no write.
- R13: `srst_i`=1 clears the counter and both flags at the next edge and cancels any pending phase two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear |
| cnt_en_i | input | 1 | Count pulse from the prescaler |
| dir_down_i | input | 1 | 1 selects down counting |
| bus_req_i | input | 1 | Starts a write cycle (phase one) |
| bus_sel_i | input | 1 | 0 selects the counter, 1 selects the status flags |
| bus_wdata_i | input | 16 | Write data |
| cnt_o | output | 16 | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with its default width of 16 bits. Both wrap boundaries are reached in a few cycles by loading 16'hFFFF or 16'h0000 through the bus, rather than by counting through 65536 steps. This lets the bench place a count pulse in phase one or in phase two of a write, at either boundary. It also lets a status clear and a wrap meet at the same edge, and a second request fall into phase two.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  typedef enum logic {
    SEL_CNT = 1'b0,
    SEL_STS = 1'b1
  } reg_sel_e;

  localparam int STS_OVF_BIT = 0;
  localparam int STS_UDF_BIT = 1;
endpackage

// File: rtl/updn_bus_phase.sv
module updn_bus_phase
  import updn_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         req_i,
  input  logic         sel_i,
  input  logic [W-1:0] wdata_i,
  output logic         ld_cnt_o,
  output logic         ld_sts_o,
  output logic [W-1:0] data_o
);
  logic         t2_q;
  reg_sel_e     sel_q;
  logic [W-1:0] data_q;

  logic take;
  assign take = req_i && !t2_q;  // requests during phase two are dropped

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t2_q   <= 1'b0;
      sel_q  <= SEL_CNT;
      data_q <= '0;
    end else if (srst_i) begin
      t2_q <= 1'b0;
    end else begin
      t2_q <= take;
      if (take) begin
        sel_q  <= reg_sel_e'(sel_i);
        data_q <= wdata_i;
      end
    end
  end

  assign ld_cnt_o = t2_q && (sel_q == SEL_CNT);
  assign ld_sts_o = t2_q && (sel_q == SEL_STS);
  assign data_o   = data_q;

  assert_no_back_to_back_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t2_q |=> !t2_q);
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         en_i,
  input  logic         down_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_evt_o,
  output logic         udf_evt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i)        cnt_d = ld_data_i;
    else if (en_i)   cnt_d = down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  // a load in phase two swallows the wrap
  assign ovf_evt_o = en_i && !down_i && !ld_i && (cnt_q == CNT_MAX);
  assign udf_evt_o = en_i &&  down_i && !ld_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (srst_i) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_load_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !srst_i) |=> cnt_q == $past(ld_data_i));
  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !en_i && !srst_i) |=> $stable(cnt_q));
endmodule

// File: rtl/updn_flags.sv
module updn_flags
  import updn_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       ovf_set_i,
  input  logic       udf_set_i,
  input  logic       wr_i,
  input  logic [1:0] wr_bits_i,
  output logic       ovf_o,
  output logic       udf_o
);
  logic ovf_q, udf_q;
  logic ovf_clr, udf_clr;

  assign ovf_clr = wr_i && !wr_bits_i[STS_OVF_BIT];
  assign udf_clr = wr_i && !wr_bits_i[STS_UDF_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (srst_i) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_set_i | (ovf_q & ~ovf_clr);  // set wins
      udf_q <= udf_set_i | (udf_q & ~udf_clr);
    end
  end

  assign ovf_o = ovf_q;
  assign udf_o = udf_q;

  assert_ovf_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_set_i && !srst_i) |=> ovf_q);
  assert_udf_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udf_set_i && !srst_i) |=> udf_q);
  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr && !srst_i) |=> ovf_q);
  assert_srst_clears_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!ovf_q && !udf_q));
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             cnt_en_i,
  input  logic             dir_down_i,
  input  logic             bus_req_i,
  input  logic             bus_sel_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic             ld_cnt, ld_sts;
  logic [CNT_W-1:0] wr_data;
  logic             ovf_evt, udf_evt;

  updn_bus_phase #(.W(CNT_W)) u_phase (
    .clk_i, .rst_ni, .srst_i,
    .req_i    (bus_req_i),
    .sel_i    (bus_sel_i),
    .wdata_i  (bus_wdata_i),
    .ld_cnt_o (ld_cnt),
    .ld_sts_o (ld_sts),
    .data_o   (wr_data)
  );

  updn_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .srst_i,
    .en_i      (cnt_en_i),
    .down_i    (dir_down_i),
    .ld_i      (ld_cnt),
    .ld_data_i (wr_data),
    .cnt_o     (cnt_o),
    .ovf_evt_o (ovf_evt),
    .udf_evt_o (udf_evt)
  );

  updn_flags u_flags (
    .clk_i, .rst_ni, .srst_i,
    .ovf_set_i (ovf_evt),
    .udf_set_i (udf_evt),
    .wr_i      (ld_sts),
    .wr_bits_i (wr_data[1:0]),
    .ovf_o     (ovf_o),
    .udf_o     (udf_o)
  );

  assert_no_ovf_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cnt && !ovf_o && !srst_i && cnt_en_i && !dir_down_i && cnt_o == {CNT_W{1'b1}})
      |=> !ovf_o);
  assert_no_udf_on_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cnt && !udf_o && !srst_i && cnt_en_i && dir_down_i && cnt_o == '0)
      |=> !udf_o);
  always_comb begin
    if (!rst_ni) assert_reset_state_R1: assert (cnt_o == '0 && !ovf_o && !udf_o);
  end
endmodule

// File: tb/updn_timer_tb.sv
`timescale 1ns/1ps
module updn_timer_tb;
  localparam int W = 16;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, srst = 1'b0;
  logic en = 1'b0, down = 1'b0, req = 1'b0, sel = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] cnt;
  logic ovf, udf;

  int checks = 0, fails = 0;
  logic [W+1:0] exp_q[$];
  string        tag_q[$];

  // behavioural model from the requirements
  logic [W-1:0] m_cnt = '0, m_data = '0;
  logic m_ovf = 0, m_udf = 0, m_t2 = 0, m_sel = 0;

  always #2.5 clk = ~clk;

  updn_timer #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .cnt_en_i(en), .dir_down_i(down),
    .bus_req_i(req), .bus_sel_i(sel), .bus_wdata_i(wdata),
    .cnt_o(cnt), .ovf_o(ovf), .udf_o(udf)
  );

  task automatic cmp(string tag, logic [W+1:0] act, logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cnt/ovf/udf actual=%h/%b/%b expected=%h/%b/%b",
               tag, act[W+1:2], act[1], act[0], exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected state after the edge
  task automatic step(input logic e, input logic d, input logic r, input logic s,
                      input logic [W-1:0] dat, input logic sr, input string tag);
    logic ldc, lds, ov, ud;
    @(negedge clk);
    en = e; down = d; req = r; sel = s; wdata = dat; srst = sr;
    ldc = m_t2 && !m_sel;
    lds = m_t2 && m_sel;
    if (sr) begin
      m_cnt = '0; m_ovf = 0; m_udf = 0; m_t2 = 0;
    end else begin
      ov = e && !d && !ldc && m_cnt == MAXV;
      ud = e &&  d && !ldc && m_cnt == '0;
      m_ovf = ov | (m_ovf & ~(lds & ~m_data[0]));
      m_udf = ud | (m_udf & ~(lds & ~m_data[1]));
      if (ldc)    m_cnt = m_data;
      else if (e) m_cnt = d ? m_cnt - 1'b1 : m_cnt + 1'b1;
      if (r && !m_t2) begin m_sel = s; m_data = dat; m_t2 = 1; end
      else m_t2 = 0;
    end
    exp_q.push_back({m_cnt, m_ovf, m_udf});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, '0, 0, tag);
  endtask

  task automatic wr(input logic s, input logic [W-1:0] dat, input string tag);
    step(0, 0, 1, s, dat, 0, tag);
    idle(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W+1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, {cnt, ovf, udf}, e);
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 cmp("R1", {cnt, ovf, udf}, '0);
    @(negedge clk) rst_n = 1'b1;

    step(1, 0, 0, 0, '0, 0, "R2 up");
    step(1, 0, 0, 0, '0, 0, "R2 up");
    step(1, 0, 0, 0, '0, 0, "R2 up");
    idle("R2 hold");
    step(1, 1, 0, 0, '0, 0, "R2 down");

    step(0, 0, 1, 0, 16'hFFF0, 0, "R5 phase1");
    idle("R5 phase2");

    wr(0, MAXV, "R3 load");
    step(1, 0, 0, 0, '0, 0, "R3 wrap");
    idle("R10 sticky");
    wr(1, 16'h0003, "R10 keep");
    wr(1, 16'h0002, "R10 clear ovf");

    wr(0, 16'h0000, "R4 load");
    step(1, 1, 0, 0, '0, 0, "R4 wrap");
    wr(1, 16'h0001, "R10 clear udf");

    wr(0, MAXV, "R7 load");
    step(0, 0, 1, 0, MAXV, 0, "R7 phase1");
    step(1, 0, 0, 0, '0, 0, "R7 R6 phase2 count");
    wr(0, 16'h0000, "R8 load");
    step(0, 0, 1, 0, 16'h1234, 0, "R8 phase1");
    step(1, 1, 0, 0, '0, 0, "R8 R6 phase2 count");

    wr(0, MAXV, "R9 load");
    step(1, 0, 1, 0, 16'h0055, 0, "R9 phase1 count");
    idle("R9 phase2");
    wr(1, 16'h0002, "R9 clear");

    wr(0, MAXV, "R11 load");
    step(0, 0, 1, 1, 16'h0002, 0, "R11 phase1");
    step(1, 0, 0, 0, '0, 0, "R11 set wins");

    step(0, 0, 1, 0, 16'h0100, 0, "R12 phase1");
    step(0, 0, 1, 0, 16'h0200, 0, "R12 req in phase2");
    idle("R12 no write");
    idle("R12 no write");

    step(1, 1, 0, 0, '0, 0, "R13 prep");
    step(0, 0, 1, 0, 16'h7777, 0, "R13 phase1");
    step(0, 0, 0, 0, '0, 1, "R13 srst");
    idle("R13 cancelled");
    step(1, 0, 0, 0, '0, 0, "R13 counts again");

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule